// File: doc/BRIEF.md
# GPIO Bank Controller

This block is a register-mapped controller for a bank of 54 general-purpose pins. It sits on a simple 32-bit word-addressed bus with a 4-bit address, a write enable, write data and a read-data return. Software chooses the direction of each pin with a 3-bit function code. It changes output levels only through write-one-to-set and write-one-to-clear words, and it reads synchronized pad levels back.

Each pin has an output latch, and that latch is always presented on the pad output. The pad output enable is asserted only while the pin's function code selects output. When a pin returns to output, it drives its stored level straight away. Pad inputs cross a two-flop synchronizer before they can be read. Reads are combinational from the current address.

Top module: `gpio_bank`

## Requirements
- R1: After reset every function field is 0 (input), every output latch is 0, `pad_oe` and `pad_out` are all zero, and function words 0 to 5 read as zero.
- R2: Pin n owns bits (n%10)*3+2 to (n%10)*3 of function word n/10 (word addresses 0 to 5). These words read back exactly what was written. Bits 30 and 31, and the bits of word 5 above pin 53 (bits 12 to 31), read as zero.
- R3: With function code 1 the pin's `pad_oe` is 1. With code 0, or with any code from 2 to 7, `pad_oe` is 0, and codes 2 to 7 are still stored and read back. `pad_oe` follows a write on the clock edge that takes the write.
- R4: Writing word 7 (pins 0 to 31) or word 8 (pins 32 to 53), with pin n at bit n%32, sets the latch of each pin whose bit is 1 and leaves the others unchanged. The new level appears on `pad_out` after the write edge.
- R5: Writing word 10 (pins 0 to 31) or word 11 (pins 32 to 53), with the same bit layout, clears the latch of each pin whose bit is 1 and leaves the others unchanged.
- R6: Set and clear words read as zero. Addresses 6, 9, 12 and 15 read as zero and writes to them change nothing. Writes to the level words 13 and 14 change nothing.
- R7: Word 13 returns the levels of pins 0 to 31 and word 14 returns pins 32 to 53 at bits 0 to 21, with bits 22 to 31 zero. A pad change is visible in the read data on the second rising clock edge after it.
- R8: An output latch keeps its value while the pin is not an output. A pin switched to code 1 drives its last latched level on the same edge that enables it.
- R9: A write to a set or clear word of one group never changes a latch in the other group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Word address |
| bus_we | input | 1 | Write enable for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 54 | Pad input levels, asynchronous |
| pad_out | output | 54 | Output latch value per pin |
| pad_oe | output | 54 | Output driver enable per pin |

## Verification
Function words are written with all-ones and with an irregular pattern. All-ones shows that the unused fields are masked and that codes 7 do not enable drivers. The irregular pattern catches field misplacement. Set and clear words are hit with sparse masks in both groups, so a missing group offset or a set bit that leaks into a clear shows up as a changed neighbour on `pad_out`. A pad pattern with bits at pin 0, pin 15 and pin 53 is sampled one edge and two edges after it changes, which tells a correct two-stage synchronizer from a one-stage or three-stage one.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int FSEL_BASE = 0;
    localparam int SET_BASE  = 7;
    localparam int CLR_BASE  = 10;
    localparam int LEV_BASE  = 13;
    localparam int FUNC_OUT  = 1;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int W = 54
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;

    // checker state: edges seen since reset, saturating
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               warm_q <= 2'd0;
        else if (warm_q != 2'd3)  warm_q <= warm_q + 2'd1;
    end

    // R7
    two_stage_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3) |-> (sync_o == $past(async_i, 2)));
endmodule

// File: rtl/gpio_bank_fsel.sv
module gpio_bank_fsel #(
    parameter int NUM_PINS = 54,
    parameter int FSEL_W   = 3,
    parameter int PER_WORD = 10,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int BASE     = 0,
    parameter int FUNC_OUT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_PINS-1:0] oe_o
);
    localparam int FLAT_W = NUM_PINS * FSEL_W;
    localparam int USED_W = PER_WORD * FSEL_W;

    typedef struct packed {
        logic [FLAT_W-1:0] fsel;
    } fsel_state_t;

    fsel_state_t st_d, st_q;

    logic unused_wdata;
    assign unused_wdata = ^wr_data[DATA_W-1:USED_W];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (addr == ADDR_W'(BASE + p / PER_WORD))
                    st_d.fsel[p*FSEL_W +: FSEL_W] = wr_data[(p % PER_WORD)*FSEL_W +: FSEL_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (addr == ADDR_W'(BASE + p / PER_WORD))
                rd_data[(p % PER_WORD)*FSEL_W +: FSEL_W] = st_q.fsel[p*FSEL_W +: FSEL_W];
        end
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_oe
        assign oe_o[p] = (st_q.fsel[p*FSEL_W +: FSEL_W] == FSEL_W'(FUNC_OUT));
    end

    // R3
    oe_follows_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(BASE)) |=>
        (oe_o[0] == ($past(wr_data[FSEL_W-1:0]) == FSEL_W'(FUNC_OUT))));
endmodule

// File: rtl/gpio_bank_outlatch.sv
module gpio_bank_outlatch #(
    parameter int NUM_PINS = 54,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int SET_BASE = 7,
    parameter int CLR_BASE = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [NUM_PINS-1:0] latch_o
);
    typedef struct packed {
        logic [NUM_PINS-1:0] lat;
    } latch_state_t;

    latch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (addr == ADDR_W'(SET_BASE + p / DATA_W) && wr_data[p % DATA_W])
                    st_d.lat[p] = 1'b1;
                if (addr == ADDR_W'(CLR_BASE + p / DATA_W) && wr_data[p % DATA_W])
                    st_d.lat[p] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latch_o = st_q.lat;

    // R4
    set_pin0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(SET_BASE) && wr_data[0]) |=> latch_o[0]);

    // R5
    clr_pin0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(CLR_BASE) && wr_data[0]) |=> !latch_o[0]);

    // R9
    low_group_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == ADDR_W'(SET_BASE) || addr == ADDR_W'(CLR_BASE)))
        |=> $stable(latch_o[DATA_W-1:0]));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 54,
    parameter int FSEL_W   = 3,
    parameter int PER_WORD = 10,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe
);
    logic [DATA_W-1:0]   fsel_rd;
    logic [DATA_W-1:0]   lvl_rd;
    logic [NUM_PINS-1:0] lvl_sync;

    gpio_bank_fsel #(
        .NUM_PINS(NUM_PINS), .FSEL_W(FSEL_W), .PER_WORD(PER_WORD),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(FSEL_BASE), .FUNC_OUT(FUNC_OUT)
    ) u_fsel (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .addr(bus_addr),
        .wr_data(bus_wdata), .rd_data(fsel_rd), .oe_o(pad_oe)
    );

    gpio_bank_outlatch #(
        .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
    ) u_latch (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .addr(bus_addr),
        .wr_data(bus_wdata), .latch_o(pad_out)
    );

    gpio_bank_sync #(.W(NUM_PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pad_in), .sync_o(lvl_sync)
    );

    always_comb begin
        lvl_rd = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (bus_addr == ADDR_W'(LEV_BASE + p / DATA_W))
                lvl_rd[p % DATA_W] = lvl_sync[p];
        end
    end

    assign bus_rdata = fsel_rd | lvl_rd;

    // R6
    strobe_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(SET_BASE) || bus_addr == ADDR_W'(SET_BASE + 1) ||
         bus_addr == ADDR_W'(CLR_BASE) || bus_addr == ADDR_W'(CLR_BASE + 1))
        |-> (bus_rdata == '0));
endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [53:0] pad_in = '0;
    logic [53:0] pad_out;
    logic [53:0] pad_oe;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    typedef struct packed {
        logic        we;
        logic [3:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd0,  32'h0,         32'h0,         4'd1}, // R1 reset readback
        '{1'b0, 4'd13, 32'h0,         32'h0,         4'd7}, // R7 quiet pads
        '{1'b1, 4'd0,  32'hFFFF_FFFF, 32'h0,         4'd2},
        '{1'b0, 4'd0,  32'h0,         32'h3FFF_FFFF, 4'd2}, // R2 bits 30,31 zero
        '{1'b1, 4'd5,  32'hFFFF_FFFF, 32'h0,         4'd2},
        '{1'b0, 4'd5,  32'h0,         32'h0000_0FFF, 4'd2}, // R2 only pins 50..53
        '{1'b1, 4'd2,  32'hDEAD_BEEF, 32'h0,         4'd2},
        '{1'b0, 4'd2,  32'h0,         32'h1EAD_BEEF, 4'd2}, // R2 irregular pattern
        '{1'b1, 4'd7,  32'h0000_00F0, 32'h0,         4'd6},
        '{1'b0, 4'd7,  32'h0,         32'h0,         4'd6}, // R6 set reads zero
        '{1'b1, 4'd11, 32'hFFFF_FFFF, 32'h0,         4'd6},
        '{1'b0, 4'd11, 32'h0,         32'h0,         4'd6}, // R6 clear reads zero
        '{1'b1, 4'd6,  32'hFFFF_FFFF, 32'h0,         4'd6},
        '{1'b0, 4'd6,  32'h0,         32'h0,         4'd6}, // R6 hole
        '{1'b0, 4'd15, 32'h0,         32'h0,         4'd6}, // R6 hole
        '{1'b0, 4'd14, 32'h0,         32'h0,         4'd7}  // R7 upper group
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        bus_we = 1'b0;
        pad_in = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        #1;
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        do_reset();
        // R1 at the ports
        chk("R1 pad_oe", 64'(pad_oe), 64'h0);
        chk("R1 pad_out", 64'(pad_out), 64'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].we) begin
                bus_write(VECS[i].addr, VECS[i].data);
            end else begin
                bus_read(VECS[i].addr, rd);
                chk($sformatf("R%0d vec%0d", VECS[i].req, i), 64'(rd), 64'(VECS[i].exp));
            end
        end
        // R3 all-ones codes (7) enable no driver
        chk("R3 code7 oe", 64'(pad_oe), 64'h0);

        do_reset();
        // R3 codes 1, 2, 7 on pins 0..2
        bus_write(4'd0, 32'h0000_01D1);
        chk("R3 oe pins0-2", 64'(pad_oe), 64'h1);
        bus_read(4'd0, rd);
        chk("R3 stored codes", 64'(rd), 64'h1D1);
        // R2 pin 47 field in word 4 bits 21..23
        bus_write(4'd4, 32'h0020_0000);
        chk("R2 pin47 oe", 64'(pad_oe), 64'h0000_8000_0000_0001);

        // R4 set and zero-bits-unchanged
        bus_write(4'd7, 32'h5);
        chk("R4 set 101", 64'(pad_out), 64'h5);
        bus_write(4'd7, 32'h2);
        chk("R4 set keeps", 64'(pad_out), 64'h7);
        // R5 clear
        bus_write(4'd10, 32'h1);
        chk("R5 clear pin0", 64'(pad_out), 64'h6);
        // R9 upper group
        bus_write(4'd8, 32'h0020_0001);
        chk("R9 set pins32,53", 64'(pad_out), 64'h0020_0001_0000_0006);
        bus_write(4'd11, 32'h1);
        chk("R9 clear pin32", 64'(pad_out), 64'h0020_0000_0000_0006);
        // R8 pin1 latched high while code 2, then enabled
        chk("R8 pin1 not driven", 64'(pad_oe[1]), 64'h0);
        bus_write(4'd0, 32'h0000_0009);
        chk("R8 pin1 driven", 64'(pad_oe[1:0]), 64'h3);
        chk("R8 pin1 level", 64'(pad_out[1]), 64'h1);

        // R7 synchronizer latency
        @(negedge clk);
        pad_in = 54'h20_0000_0000_8001;
        @(posedge clk);
        #1;
        bus_read(4'd13, rd);
        chk("R7 one edge", 64'(rd), 64'h0);
        @(posedge clk);
        #1;
        bus_read(4'd13, rd);
        chk("R7 low group", 64'(rd), 64'h8001);
        bus_read(4'd14, rd);
        chk("R7 high group", 64'(rd), 64'h0020_0000);
        // R6 level words ignore writes
        bus_write(4'd14, 32'hFFFF_FFFF);
        bus_read(4'd14, rd);
        chk("R6 level write ignored", 64'(rd), 64'h0020_0000);
        bus_write(4'd9, 32'hFFFF_FFFF);
        chk("R6 hole write ignored", 64'(pad_out), 64'h0020_0000_0000_0006);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule